// File: doc/BRIEF.md
# Clear-on-Read Event Counter Bank with Byte Snapshot

This block keeps a set of 16-bit event counters for performance monitoring and makes them readable over an 8-bit processor data bus. Each counter takes single-cycle event pulses and counts them up. It has two byte addresses: the high byte sits at an even offset from a base address, and the low byte sits at the next address.

When the processor reads either byte of a counter, the block takes a snapshot of the whole 16-bit value at that moment. It returns the requested byte and puts the other byte into a shared read-only holding register. It then clears the counter. A following read of the holding register returns the remaining byte, so software always gets two halves of the same value even though the counter keeps running.

Read side effects happen once for each read strobe, on the cycle in which the strobe is first seen high. The read data output is registered and keeps its value until the next read strobe.

Top module: `evt_cnt_bank`

## Requirements
- R1: After synchronous reset, every counter, the holding register and `rd_data_o` are 0x00.
- R2: Each clock cycle in which `evt_i[k]` is high adds exactly one to counter k. Counters do not affect one another.
- R3: A counter that has reached 0xFFFF stays at 0xFFFF while further events arrive. It does not wrap.
- R4: A read strobe edge at address `BASE_ADDR + 2k` returns bits 15:8 of counter k, and one at `BASE_ADDR + 2k + 1` returns bits 7:0. The value is the count before that clock edge, and it appears on `rd_data_o` one cycle after the edge.
- R5: The same counter read loads the other byte of that same snapshot into the holding register.
- R6: A counter byte read clears both bytes of that counter.
- R7: If counter k's event is high in the cycle of its clearing read, the counter becomes 1 instead of 0.
- R8: A read at `HOLD_ADDR` (default 0x6C) returns the holding register. It changes no counter and leaves the holding register as it was.
- R9: Holding the strobe high for several cycles causes only one clear and one holding-register load.
- R10: A read at any other address returns 0x00 and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_CNT | One event-pulse input per counter |
| rd_stb_i | input | 1 | Read strobe; acted on when it first goes high |
| rd_addr_i | input | ADDR_W | Byte address of the read |
| rd_data_o | output | 8 | Registered read data |

## Verification
A reference model of the counters and the holding register predicts every returned byte. The stimulus includes:
- A high-byte read followed by a holding read, which checks that the two halves come from the same snapshot.
- A low-byte-first order, which separates the high and low byte paths.
- A read of a counter that was just cleared, which shows the clear.
- A read with the counter's own event high in the same cycle, which shows the 0-versus-1 reload.
- A strobe held for four cycles while events continue, which shows whether the clear repeats.
- Back-to-back holding reads and an unmapped address, which show that neither disturbs any state.
- A run of more than 65,535 events, which shows whether the counter saturates or wraps.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 8;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic             hit_cnt;
        logic             hit_hold;
        logic             lsb;
        logic [IDX_W-1:0] idx;
    } rd_dec_t;

    function automatic cnt_t sat_inc(input cnt_t v);
        return (v == '1) ? v : v + cnt_t'(1);
    endfunction

    function automatic byte_t pick_byte(input cnt_t v, input logic lo);
        return lo ? v[BYTE_W-1:0] : v[CNT_W-1:BYTE_W];
    endfunction
endpackage

// File: rtl/evt_cnt_edge.sv
module evt_cnt_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign pulse = lvl & ~prev_q;
endmodule

// File: rtl/evt_cnt_dec.sv
module evt_cnt_dec
    import evt_cnt_pkg::*;
#(
    parameter int N_CNT     = 4,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h50,
    parameter int HOLD_ADDR = 'h6C
) (
    input  logic [ADDR_W-1:0] addr,
    output rd_dec_t           dec
);
    localparam int SPAN = 2 * N_CNT;

    int off;

    always_comb begin
        off          = int'(addr) - BASE_ADDR;
        dec          = '0;
        dec.hit_cnt  = (off >= 0) && (off < SPAN);
        dec.hit_hold = (int'(addr) == HOLD_ADDR);
        dec.lsb      = addr[0] ^ BASE_ADDR[0];
        if (dec.hit_cnt) dec.idx = IDX_W'(off >>> 1);
    end
endmodule

// File: rtl/evt_cnt_cell.sv
module evt_cnt_cell
    import evt_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    output cnt_t cnt
);
    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (clr) cnt_q <= evt ? cnt_t'(1) : '0;
        else if (evt) cnt_q <= sat_inc(cnt_q);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
    import evt_cnt_pkg::*;
#(
    parameter int N_CNT     = 4,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h50,
    parameter int HOLD_ADDR = 'h6C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CNT-1:0]  evt_i,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    logic                   rd_pulse;
    rd_dec_t                dec;
    logic [N_CNT-1:0]       clr_vec;
    cnt_t                   cnt_arr [N_CNT];
    logic [N_CNT*CNT_W-1:0] cnt_flat;
    cnt_t                   sel_cnt;
    byte_t                  hold_q;
    byte_t                  rd_q;

    evt_cnt_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl   (rd_stb_i),
        .pulse (rd_pulse)
    );

    evt_cnt_dec #(
        .N_CNT     (N_CNT),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .HOLD_ADDR (HOLD_ADDR)
    ) u_dec (
        .addr (rd_addr_i),
        .dec  (dec)
    );

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        assign clr_vec[g] = rd_pulse & dec.hit_cnt & (int'(dec.idx) == g);

        evt_cnt_cell u_cell (
            .clk (clk),
            .rst (rst),
            .evt (evt_i[g]),
            .clr (clr_vec[g]),
            .cnt (cnt_arr[g])
        );

        assign cnt_flat[g*CNT_W +: CNT_W] = cnt_arr[g];
    end

    always_comb begin
        sel_cnt = '0;
        for (int i = 0; i < N_CNT; i++) begin
            if (int'(dec.idx) == i) sel_cnt = cnt_arr[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            rd_q   <= '0;
        end else if (rd_pulse) begin
            if (dec.hit_cnt) begin
                rd_q   <= pick_byte(sel_cnt, dec.lsb);
                hold_q <= pick_byte(sel_cnt, ~dec.lsb);
            end else if (dec.hit_hold) begin
                rd_q   <= hold_q;
            end else begin
                rd_q   <= '0;
            end
        end
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/evt_cnt_bank_chk.sv
module evt_cnt_bank_chk #(
    parameter int N_CNT = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          rd_data_o,
    input logic                rd_pulse,
    input logic [N_CNT-1:0]    clr_vec,
    input logic [N_CNT*16-1:0] cnt_flat,
    input logic [7:0]          hold_q
);
    a_r1_reset_data: assert property (@(posedge clk) rst |=> (rd_data_o == 8'h00));

    a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
        !rd_pulse |=> $stable(hold_q));

    for (genvar g = 0; g < N_CNT; g++) begin : g_chk
        a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
            !clr_vec[g] |=> (cnt_flat[g*16 +: 16] == $past(cnt_flat[g*16 +: 16]))
                         || (cnt_flat[g*16 +: 16] == $past(cnt_flat[g*16 +: 16]) + 16'd1));

        a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
            (!clr_vec[g] && cnt_flat[g*16 +: 16] == 16'hFFFF) |=> (cnt_flat[g*16 +: 16] == 16'hFFFF));

        a_r6_cleared: assert property (@(posedge clk) disable iff (rst)
            clr_vec[g] |=> (cnt_flat[g*16 +: 16] <= 16'd1));
    end
endmodule

bind evt_cnt_bank evt_cnt_bank_chk #(.N_CNT(N_CNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_data_o (rd_data_o),
    .rd_pulse  (rd_pulse),
    .clr_vec   (clr_vec),
    .cnt_flat  (cnt_flat),
    .hold_q    (hold_q)
);

// File: tb/evt_cnt_bank_bench.sv
module evt_cnt_bank_bench;
    localparam int N    = 4;
    localparam int BASE = 'h50;
    localparam int HOLD = 'h6C;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] evt = '0;
    logic         stb = 1'b0;
    logic [7:0]   addr = '0;
    logic [7:0]   rd_data;

    evt_cnt_bank #(.N_CNT(N), .ADDR_W(8), .BASE_ADDR(BASE), .HOLD_ADDR(HOLD)) u_evt_cnt_bank (
        .clk (clk), .rst (rst), .evt_i (evt), .rd_stb_i (stb),
        .rd_addr_i (addr), .rd_data_o (rd_data)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t        q[$];
    int           n_chk = 0;
    int           n_bad = 0;
    logic [15:0]  mdl [N];
    logic [7:0]   mhold = 8'h00;
    bit           done = 0;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(rd_data, it.exp, it.tag);
        end
    end

    function automatic void model_evt(input logic [N-1:0] m);
        for (int k = 0; k < N; k++)
            if (m[k] && mdl[k] != 16'hFFFF) mdl[k] = mdl[k] + 16'd1;
    endfunction

    task automatic run_evt(input logic [N-1:0] m, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            evt = m;
            model_evt(m);
        end
        @(negedge clk);
        evt = '0;
    endtask

    // Read with strobe held for 'held' cycles and event mask 'm' during them.
    task automatic rd(input logic [7:0] a, input logic [N-1:0] m, input int held, input string tag);
        logic [7:0] e;
        int         off;
        item_t      it;
        @(negedge clk);
        addr = a;
        stb  = 1'b1;
        evt  = m;
        off  = int'(a) - BASE;
        if (off >= 0 && off < 2 * N) begin
            int k;
            k = off / 2;
            e = off[0] ? mdl[k][7:0] : mdl[k][15:8];
            mhold = off[0] ? mdl[k][15:8] : mdl[k][7:0];
            for (int j = 0; j < N; j++)
                if (j == k) mdl[j] = m[j] ? 16'd1 : 16'd0;
                else if (m[j] && mdl[j] != 16'hFFFF) mdl[j] = mdl[j] + 16'd1;
        end else begin
            e = (int'(a) == HOLD) ? mhold : 8'h00;
            model_evt(m);
        end
        @(posedge clk);
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
        for (int c = 1; c < held; c++) begin
            @(negedge clk);
            model_evt(m);
        end
        @(negedge clk);
        stb = 1'b0;
        evt = '0;
    endtask

    initial begin
        for (int k = 0; k < N; k++) mdl[k] = 16'h0000;
        repeat (3) @(negedge clk);
        check(rd_data, 8'h00, "R1 reset data");
        rst = 1'b0;
        rd(8'(BASE), '0, 1, "R1 counter after reset");
        rd(8'(HOLD), '0, 1, "R1 hold after reset");

        run_evt(4'b0001, 5);
        run_evt(4'b0010, 300);
        rd(8'(BASE + 2), '0, 1, "R4 msb of counter1");
        rd(8'(HOLD), '0, 1, "R5 hold gets lsb");
        rd(8'(BASE + 3), '0, 1, "R6 counter1 cleared");
        rd(8'(HOLD), '0, 1, "R6 hold of cleared counter");
        rd(8'(BASE + 1), '0, 1, "R2 lsb of counter0");
        rd(8'(HOLD), '0, 1, "R5 hold gets msb");

        run_evt(4'b0100, 3);
        rd(8'(BASE + 5), 4'b0100, 4, "R9 held strobe snapshot");
        rd(8'(BASE + 5), '0, 1, "R9 single clear while held");

        run_evt(4'b1000, 10);
        rd(8'(BASE + 7), 4'b1000, 1, "R7 snapshot with event");
        run_evt(4'b0001, 258);
        rd(8'(BASE + 1), '0, 1, "R4 lsb of counter0");
        run_evt(4'b1000, 7);
        rd(8'(HOLD), '0, 1, "R8 first hold read");
        rd(8'(HOLD), '0, 1, "R8 second hold read");
        rd(8'(BASE + 7), '0, 1, "R7 reload to one then count");
        rd(8'(BASE + 6), '0, 1, "R8 msb after hold reads");

        run_evt(4'b0100, 2);
        rd(8'h40, '0, 1, "R10 unmapped read");
        rd(8'(HOLD), '0, 1, "R10 hold untouched");
        rd(8'(BASE + 5), '0, 1, "R10 counter untouched");

        run_evt(4'b0010, 65540);
        rd(8'(BASE + 2), '0, 1, "R3 saturated msb");
        rd(8'(HOLD), '0, 1, "R3 saturated lsb");

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule